// File: doc/BRIEF.md
# Regulator Hardware Control Override Resolver

This block decides, every clock, what each regulator channel of a power management device should actually do. It serves a set of buck converters, a set of linear regulators and a few external power enable outputs. For each channel it combines a software enable, an optional hardware enable, the settings for the awake and sleep states, and a set of override fields. A per-channel source field picks one of several asynchronous hardware control inputs. When the picked input is high and the channel is enabled, the override fields win over the awake and sleep settings.

Linear regulators can also act as current-limited switches. The switch flag can only be written while the device is awake. A linear regulator that is off can either leave its output floating or actively discharge it. When two bucks are ganged, they are never left in the auto (pulse-skipping) mode: that mode is turned into forced continuous conduction. All outputs are registered. The hardware control inputs pass through a two-flop synchroniser first.

Top module: `rhc_top`

## Requirements
- R1: A change on a hardware control input reaches the outputs on the third rising clock edge after it, and not on the second.
- R2: A source field of 0 selects no hardware control input. A value k from 1 to the input count selects input bit k-1.
- R3: A channel is enabled when its software enable or its hardware enable is 1. The selected hardware control input only applies to an enabled channel. A channel that is not enabled keeps the mode and voltage of its normal settings.
- R4: Device state code 2'b01 (sleep) selects the sleep mode and voltage. Every other code selects the awake settings. For a buck with an active override, the override mode and voltage replace both.
- R5: A buck override mode of 2'b01 drives that buck's enable output to 0.
- R6: An active override on a linear regulator replaces its mode and voltage. A mode whose bit 0 is 0 (codes 00 and 10) is low power. The low-power-type output then equals the regulator's type bit, and it is 0 for any other mode.
- R7: An external enable output with an active override is forced to 0 when its override option bit is 1. When the option bit is 0, the output follows the channel enable.
- R8: When a linear regulator's switch flag is set, its mode, voltage and low-power-type outputs read 0, and its switch output is 1 exactly when the channel is enabled.
- R9: A linear regulator that is not enabled and not in switch mode drives its discharge output to 1 when its float bit is 0. When its float bit is 1, the discharge output is 0.
- R10: The switch flags reset to 0. A write updates them only when the device state is 2'b10 (awake), and the change reaches the outputs one edge after the flags update. A write in any other state is ignored.
- R11: When the gang input is 1, an auto mode (2'b10) on either ganged buck is output as forced continuous (2'b00). Other modes are not changed.
- R12: A change on any configuration input appears at the outputs after one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_state | input | 2 | Device state: 01 sleep, 10 awake |
| dual_gang | input | 1 | Ganged-buck mode |
| hwc_in | input | NUM_HWC | Asynchronous hardware control inputs |
| buck_sw_en | input | NUM_BUCK | Buck software enables |
| buck_hw_en | input | NUM_BUCK | Buck hardware enables |
| buck_src | input | NUM_BUCK*SRC_W | Buck control source select |
| buck_on_mode | input | NUM_BUCK*2 | Buck awake mode |
| buck_on_vsel | input | NUM_BUCK*VSEL_W | Buck awake voltage code |
| buck_slp_mode | input | NUM_BUCK*2 | Buck sleep mode |
| buck_slp_vsel | input | NUM_BUCK*VSEL_W | Buck sleep voltage code |
| buck_ovr_mode | input | NUM_BUCK*2 | Buck override mode |
| buck_ovr_vsel | input | NUM_BUCK*VSEL_W | Buck override voltage code |
| ldo_sw_en | input | NUM_LDO | Linear regulator software enables |
| ldo_hw_en | input | NUM_LDO | Linear regulator hardware enables |
| ldo_src | input | NUM_LDO*SRC_W | Linear regulator control source select |
| ldo_on_mode | input | NUM_LDO*2 | Awake mode |
| ldo_on_vsel | input | NUM_LDO*VSEL_W | Awake voltage code |
| ldo_slp_mode | input | NUM_LDO*2 | Sleep mode |
| ldo_slp_vsel | input | NUM_LDO*VSEL_W | Sleep voltage code |
| ldo_ovr_mode | input | NUM_LDO*2 | Override mode |
| ldo_ovr_vsel | input | NUM_LDO*VSEL_W | Override voltage code |
| ldo_lp_type | input | NUM_LDO | Low-power type bit |
| ldo_float | input | NUM_LDO | 1: float when off, 0: discharge |
| swi_wr | input | 1 | Switch flag write strobe |
| swi_wdata | input | NUM_LDO | Switch flag write data |
| epe_sw_en | input | NUM_EPE | External enable software enables |
| epe_hw_en | input | NUM_EPE | External enable hardware enables |
| epe_src | input | NUM_EPE*SRC_W | External enable control source select |
| epe_ovr_off | input | NUM_EPE | 1: override forces output low |
| buck_ena | output | NUM_BUCK | Effective buck enables |
| buck_mode | output | NUM_BUCK*2 | Effective buck modes |
| buck_vsel | output | NUM_BUCK*VSEL_W | Effective buck voltage codes |
| ldo_ena | output | NUM_LDO | Effective regulator enables |
| ldo_mode | output | NUM_LDO*2 | Effective regulator modes |
| ldo_vsel | output | NUM_LDO*VSEL_W | Effective regulator voltage codes |
| ldo_lp | output | NUM_LDO | Effective low-power type |
| ldo_sw | output | NUM_LDO | Switch closed |
| ldo_dis | output | NUM_LDO | Active discharge on |
| epe_out | output | NUM_EPE | External enable outputs |

## Verification
Two resolutions can land on one buck in the same cycle: the hardware override that picks the mode, and the ganged coercion that rewrites auto mode. The table drives vectors where the ganged buck's override mode is auto with the gang input high, and vectors where the auto mode comes from the awake setting instead. In both cases the expected mode is forced continuous, and a hysteretic sleep mode must stay unchanged. In a second case, the switch flag and the off-state discharge choice act on the same regulator in one cycle. Disabling a regulator while it is in switch mode must give an open switch and no discharge.

// File: rtl/rhc_pkg.sv
package rhc_pkg;
  localparam int MODE_W = 2;
  localparam logic [1:0] ST_SLEEP = 2'b01;
  localparam logic [1:0] ST_AWAKE = 2'b10;
  localparam logic [1:0] BK_FCCM  = 2'b00;
  localparam logic [1:0] BK_OFF   = 2'b01;
  localparam logic [1:0] BK_AUTO  = 2'b10;
endpackage

// File: rtl/rhc_sync.sv
module rhc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      q    <= '0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/rhc_pick.sv
module rhc_pick #(
  parameter int N     = 3,
  parameter int SRC_W = 2
) (
  input  logic [SRC_W-1:0] src,
  input  logic [N-1:0]     hwc,
  output logic             hit
);
  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (src == SRC_W'(k + 1)) hit = hwc[k];
    end
  end
endmodule

// File: rtl/rhc_buck_nx.sv
module rhc_buck_nx
  import rhc_pkg::*;
#(
  parameter int VSEL_W = 7,
  parameter bit GANGED = 1'b0
) (
  input  logic              sw_en,
  input  logic              hw_en,
  input  logic              sleep,
  input  logic              dual,
  input  logic              hit,
  input  logic [MODE_W-1:0] on_mode,
  input  logic [VSEL_W-1:0] on_vsel,
  input  logic [MODE_W-1:0] slp_mode,
  input  logic [VSEL_W-1:0] slp_vsel,
  input  logic [MODE_W-1:0] ovr_mode,
  input  logic [VSEL_W-1:0] ovr_vsel,
  output logic              ena_nx,
  output logic [MODE_W-1:0] mode_nx,
  output logic [VSEL_W-1:0] vsel_nx
);
  logic en, ovr;
  always_comb begin
    en  = sw_en | hw_en;
    ovr = hit & en;
    if (ovr) begin
      mode_nx = ovr_mode;
      vsel_nx = ovr_vsel;
    end else if (sleep) begin
      mode_nx = slp_mode;
      vsel_nx = slp_vsel;
    end else begin
      mode_nx = on_mode;
      vsel_nx = on_vsel;
    end
    if (GANGED && dual && (mode_nx == BK_AUTO)) mode_nx = BK_FCCM;
    ena_nx = en & ~(ovr & (ovr_mode == BK_OFF));
  end
endmodule

// File: rtl/rhc_ldo_nx.sv
module rhc_ldo_nx
  import rhc_pkg::*;
#(
  parameter int VSEL_W = 7
) (
  input  logic              sw_en,
  input  logic              hw_en,
  input  logic              sleep,
  input  logic              hit,
  input  logic              swi,
  input  logic              flt,
  input  logic              lp_type,
  input  logic [MODE_W-1:0] on_mode,
  input  logic [VSEL_W-1:0] on_vsel,
  input  logic [MODE_W-1:0] slp_mode,
  input  logic [VSEL_W-1:0] slp_vsel,
  input  logic [MODE_W-1:0] ovr_mode,
  input  logic [VSEL_W-1:0] ovr_vsel,
  output logic              ena_nx,
  output logic [MODE_W-1:0] mode_nx,
  output logic [VSEL_W-1:0] vsel_nx,
  output logic              lp_nx,
  output logic              sw_nx,
  output logic              dis_nx
);
  logic en;
  always_comb begin
    en = sw_en | hw_en;
    if (hit & en) begin
      mode_nx = ovr_mode;
      vsel_nx = ovr_vsel;
    end else if (sleep) begin
      mode_nx = slp_mode;
      vsel_nx = slp_vsel;
    end else begin
      mode_nx = on_mode;
      vsel_nx = on_vsel;
    end
    lp_nx = ~mode_nx[0] & lp_type;
    sw_nx = 1'b0;
    if (swi) begin
      mode_nx = '0;
      vsel_nx = '0;
      lp_nx   = 1'b0;
      sw_nx   = en;
    end
    ena_nx = en;
    dis_nx = ~en & ~swi & ~flt;
  end
endmodule

// File: rtl/rhc_top.sv
module rhc_top
  import rhc_pkg::*;
#(
  parameter int NUM_BUCK = 4,
  parameter int NUM_LDO  = 4,
  parameter int NUM_EPE  = 2,
  parameter int NUM_HWC  = 3,
  parameter int VSEL_W   = 7,
  parameter int GANG_LO  = 2,
  localparam int SRC_W   = $clog2(NUM_HWC + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   pwr_state,
  input  logic                         dual_gang,
  input  logic [NUM_HWC-1:0]           hwc_in,
  input  logic [NUM_BUCK-1:0]          buck_sw_en,
  input  logic [NUM_BUCK-1:0]          buck_hw_en,
  input  logic [NUM_BUCK*SRC_W-1:0]    buck_src,
  input  logic [NUM_BUCK*MODE_W-1:0]   buck_on_mode,
  input  logic [NUM_BUCK*VSEL_W-1:0]   buck_on_vsel,
  input  logic [NUM_BUCK*MODE_W-1:0]   buck_slp_mode,
  input  logic [NUM_BUCK*VSEL_W-1:0]   buck_slp_vsel,
  input  logic [NUM_BUCK*MODE_W-1:0]   buck_ovr_mode,
  input  logic [NUM_BUCK*VSEL_W-1:0]   buck_ovr_vsel,
  input  logic [NUM_LDO-1:0]           ldo_sw_en,
  input  logic [NUM_LDO-1:0]           ldo_hw_en,
  input  logic [NUM_LDO*SRC_W-1:0]     ldo_src,
  input  logic [NUM_LDO*MODE_W-1:0]    ldo_on_mode,
  input  logic [NUM_LDO*VSEL_W-1:0]    ldo_on_vsel,
  input  logic [NUM_LDO*MODE_W-1:0]    ldo_slp_mode,
  input  logic [NUM_LDO*VSEL_W-1:0]    ldo_slp_vsel,
  input  logic [NUM_LDO*MODE_W-1:0]    ldo_ovr_mode,
  input  logic [NUM_LDO*VSEL_W-1:0]    ldo_ovr_vsel,
  input  logic [NUM_LDO-1:0]           ldo_lp_type,
  input  logic [NUM_LDO-1:0]           ldo_float,
  input  logic                         swi_wr,
  input  logic [NUM_LDO-1:0]           swi_wdata,
  input  logic [NUM_EPE-1:0]           epe_sw_en,
  input  logic [NUM_EPE-1:0]           epe_hw_en,
  input  logic [NUM_EPE*SRC_W-1:0]     epe_src,
  input  logic [NUM_EPE-1:0]           epe_ovr_off,
  output logic [NUM_BUCK-1:0]          buck_ena,
  output logic [NUM_BUCK*MODE_W-1:0]   buck_mode,
  output logic [NUM_BUCK*VSEL_W-1:0]   buck_vsel,
  output logic [NUM_LDO-1:0]           ldo_ena,
  output logic [NUM_LDO*MODE_W-1:0]    ldo_mode,
  output logic [NUM_LDO*VSEL_W-1:0]    ldo_vsel,
  output logic [NUM_LDO-1:0]           ldo_lp,
  output logic [NUM_LDO-1:0]           ldo_sw,
  output logic [NUM_LDO-1:0]           ldo_dis,
  output logic [NUM_EPE-1:0]           epe_out
);
  logic                 rst_sync_n;
  logic [NUM_HWC-1:0]   hwc_q;
  logic                 sleep;
  logic [NUM_LDO-1:0]   swi_q, swi_nx;
  logic                 swi_we;

  logic [NUM_BUCK-1:0]        b_ena_nx;
  logic [NUM_BUCK*MODE_W-1:0] b_mode_nx;
  logic [NUM_BUCK*VSEL_W-1:0] b_vsel_nx;
  logic [NUM_LDO-1:0]         l_ena_nx, l_lp_nx, l_sw_nx, l_dis_nx;
  logic [NUM_LDO*MODE_W-1:0]  l_mode_nx;
  logic [NUM_LDO*VSEL_W-1:0]  l_vsel_nx;
  logic [NUM_EPE-1:0]         e_out_nx;

  rhc_sync #(.W(1)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n));

  rhc_sync #(.W(NUM_HWC)) u_hwc_sync (
    .clk(clk), .rst_n(rst_n), .d(hwc_in), .q(hwc_q));

  assign sleep = (pwr_state == ST_SLEEP);

  always_comb begin
    swi_we = swi_wr & (pwr_state == ST_AWAKE);
    swi_nx = swi_we ? swi_wdata : swi_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) swi_q <= '0;
    else             swi_q <= swi_nx;
  end

  for (genvar i = 0; i < NUM_BUCK; i++) begin : g_buck
    logic hit;
    rhc_pick #(.N(NUM_HWC), .SRC_W(SRC_W)) u_pick (
      .src(buck_src[i*SRC_W +: SRC_W]), .hwc(hwc_q), .hit(hit));
    rhc_buck_nx #(.VSEL_W(VSEL_W),
                  .GANGED((i == GANG_LO) || (i == GANG_LO + 1))) u_nx (
      .sw_en(buck_sw_en[i]), .hw_en(buck_hw_en[i]), .sleep(sleep),
      .dual(dual_gang), .hit(hit),
      .on_mode(buck_on_mode[i*MODE_W +: MODE_W]),
      .on_vsel(buck_on_vsel[i*VSEL_W +: VSEL_W]),
      .slp_mode(buck_slp_mode[i*MODE_W +: MODE_W]),
      .slp_vsel(buck_slp_vsel[i*VSEL_W +: VSEL_W]),
      .ovr_mode(buck_ovr_mode[i*MODE_W +: MODE_W]),
      .ovr_vsel(buck_ovr_vsel[i*VSEL_W +: VSEL_W]),
      .ena_nx(b_ena_nx[i]),
      .mode_nx(b_mode_nx[i*MODE_W +: MODE_W]),
      .vsel_nx(b_vsel_nx[i*VSEL_W +: VSEL_W]));
  end

  for (genvar i = 0; i < NUM_LDO; i++) begin : g_ldo
    logic hit;
    rhc_pick #(.N(NUM_HWC), .SRC_W(SRC_W)) u_pick (
      .src(ldo_src[i*SRC_W +: SRC_W]), .hwc(hwc_q), .hit(hit));
    rhc_ldo_nx #(.VSEL_W(VSEL_W)) u_nx (
      .sw_en(ldo_sw_en[i]), .hw_en(ldo_hw_en[i]), .sleep(sleep),
      .hit(hit), .swi(swi_q[i]), .flt(ldo_float[i]),
      .lp_type(ldo_lp_type[i]),
      .on_mode(ldo_on_mode[i*MODE_W +: MODE_W]),
      .on_vsel(ldo_on_vsel[i*VSEL_W +: VSEL_W]),
      .slp_mode(ldo_slp_mode[i*MODE_W +: MODE_W]),
      .slp_vsel(ldo_slp_vsel[i*VSEL_W +: VSEL_W]),
      .ovr_mode(ldo_ovr_mode[i*MODE_W +: MODE_W]),
      .ovr_vsel(ldo_ovr_vsel[i*VSEL_W +: VSEL_W]),
      .ena_nx(l_ena_nx[i]),
      .mode_nx(l_mode_nx[i*MODE_W +: MODE_W]),
      .vsel_nx(l_vsel_nx[i*VSEL_W +: VSEL_W]),
      .lp_nx(l_lp_nx[i]), .sw_nx(l_sw_nx[i]), .dis_nx(l_dis_nx[i]));
  end

  for (genvar i = 0; i < NUM_EPE; i++) begin : g_epe
    logic hit;
    rhc_pick #(.N(NUM_HWC), .SRC_W(SRC_W)) u_pick (
      .src(epe_src[i*SRC_W +: SRC_W]), .hwc(hwc_q), .hit(hit));
    always_comb begin
      e_out_nx[i] = (epe_sw_en[i] | epe_hw_en[i]) & ~(hit & epe_ovr_off[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      buck_ena  <= '0;
      buck_mode <= '0;
      buck_vsel <= '0;
      ldo_ena   <= '0;
      ldo_mode  <= '0;
      ldo_vsel  <= '0;
      ldo_lp    <= '0;
      ldo_sw    <= '0;
      ldo_dis   <= '0;
      epe_out   <= '0;
    end else begin
      buck_ena  <= b_ena_nx;
      buck_mode <= b_mode_nx;
      buck_vsel <= b_vsel_nx;
      ldo_ena   <= l_ena_nx;
      ldo_mode  <= l_mode_nx;
      ldo_vsel  <= l_vsel_nx;
      ldo_lp    <= l_lp_nx;
      ldo_sw    <= l_sw_nx;
      ldo_dis   <= l_dis_nx;
      epe_out   <= e_out_nx;
    end
  end
endmodule

// File: rtl/rhc_top_chk.sv
module rhc_top_chk #(
  parameter int NUM_BUCK = 4,
  parameter int NUM_LDO  = 4,
  parameter int NUM_EPE  = 2,
  parameter int GANG_LO  = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            pwr_state,
  input logic                  dual_gang,
  input logic [NUM_LDO-1:0]    swi_q,
  input logic [NUM_BUCK-1:0]   buck_sw_en,
  input logic [NUM_BUCK-1:0]   buck_hw_en,
  input logic [NUM_BUCK-1:0]   buck_ena,
  input logic [NUM_BUCK*2-1:0] buck_mode,
  input logic [NUM_LDO-1:0]    ldo_ena,
  input logic [NUM_LDO-1:0]    ldo_sw,
  input logic [NUM_LDO-1:0]    ldo_dis,
  input logic [NUM_EPE-1:0]    epe_sw_en,
  input logic [NUM_EPE-1:0]    epe_hw_en,
  input logic [NUM_EPE-1:0]    epe_out
);
  // R10
  swi_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'b10) |=> $stable(swi_q));

  // R11
  gang_fccm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dual_gang |=> ((buck_mode[GANG_LO*2 +: 2] != 2'b10) &&
                   (buck_mode[(GANG_LO+1)*2 +: 2] != 2'b10)));

  // R9
  dis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ldo_dis & ldo_ena) == '0);

  // R8
  sw_nodis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ldo_dis & ldo_sw) == '0);

  // R3
  epe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((epe_out & ~$past(epe_sw_en | epe_hw_en)) == '0));

  // R3
  buck_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((buck_ena & ~$past(buck_sw_en | buck_hw_en)) == '0));
endmodule

bind rhc_top rhc_top_chk #(
  .NUM_BUCK(NUM_BUCK), .NUM_LDO(NUM_LDO), .NUM_EPE(NUM_EPE), .GANG_LO(GANG_LO)
) i_rhc_top_chk (
  .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .dual_gang(dual_gang),
  .swi_q(swi_q), .buck_sw_en(buck_sw_en), .buck_hw_en(buck_hw_en),
  .buck_ena(buck_ena), .buck_mode(buck_mode), .ldo_ena(ldo_ena),
  .ldo_sw(ldo_sw), .ldo_dis(ldo_dis), .epe_sw_en(epe_sw_en),
  .epe_hw_en(epe_hw_en), .epe_out(epe_out));

// File: tb/test_rhc_top.sv
module test_rhc_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  pwr_state;
  logic        dual_gang;
  logic [2:0]  hwc_in;
  logic [3:0]  buck_sw_en, buck_hw_en;
  logic [7:0]  buck_src, buck_on_mode, buck_slp_mode, buck_ovr_mode;
  logic [27:0] buck_on_vsel, buck_slp_vsel, buck_ovr_vsel;
  logic [3:0]  ldo_sw_en, ldo_hw_en, ldo_lp_type, ldo_float;
  logic [7:0]  ldo_src, ldo_on_mode, ldo_slp_mode, ldo_ovr_mode;
  logic [27:0] ldo_on_vsel, ldo_slp_vsel, ldo_ovr_vsel;
  logic        swi_wr;
  logic [3:0]  swi_wdata;
  logic [1:0]  epe_sw_en, epe_hw_en, epe_ovr_off;
  logic [3:0]  epe_src;
  logic [3:0]  buck_ena, ldo_ena, ldo_lp, ldo_sw, ldo_dis;
  logic [7:0]  buck_mode, ldo_mode;
  logic [27:0] buck_vsel, ldo_vsel;
  logic [1:0]  epe_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rhc_top i_rhc_top (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .dual_gang(dual_gang),
    .hwc_in(hwc_in), .buck_sw_en(buck_sw_en), .buck_hw_en(buck_hw_en),
    .buck_src(buck_src), .buck_on_mode(buck_on_mode), .buck_on_vsel(buck_on_vsel),
    .buck_slp_mode(buck_slp_mode), .buck_slp_vsel(buck_slp_vsel),
    .buck_ovr_mode(buck_ovr_mode), .buck_ovr_vsel(buck_ovr_vsel),
    .ldo_sw_en(ldo_sw_en), .ldo_hw_en(ldo_hw_en), .ldo_src(ldo_src),
    .ldo_on_mode(ldo_on_mode), .ldo_on_vsel(ldo_on_vsel),
    .ldo_slp_mode(ldo_slp_mode), .ldo_slp_vsel(ldo_slp_vsel),
    .ldo_ovr_mode(ldo_ovr_mode), .ldo_ovr_vsel(ldo_ovr_vsel),
    .ldo_lp_type(ldo_lp_type), .ldo_float(ldo_float),
    .swi_wr(swi_wr), .swi_wdata(swi_wdata),
    .epe_sw_en(epe_sw_en), .epe_hw_en(epe_hw_en), .epe_src(epe_src),
    .epe_ovr_off(epe_ovr_off),
    .buck_ena(buck_ena), .buck_mode(buck_mode), .buck_vsel(buck_vsel),
    .ldo_ena(ldo_ena), .ldo_mode(ldo_mode), .ldo_vsel(ldo_vsel),
    .ldo_lp(ldo_lp), .ldo_sw(ldo_sw), .ldo_dis(ldo_dis), .epe_out(epe_out));

  // hwc, state, gang -> buck0 ena, buck2 mode/vsel, ldo0 mode/vsel/lp, epe
  typedef struct packed {
    logic [2:0] hwc;
    logic [1:0] st;
    logic       dual;
    logic       b0e;
    logic [1:0] b2m;
    logic [6:0] b2v;
    logic [1:0] l0m;
    logic [6:0] l0v;
    logic       l0lp;
    logic [1:0] epe;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{3'b000, 2'b10, 1'b0, 1'b1, 2'b10, 7'h20, 2'b01, 7'h11, 1'b0, 2'b11},
    '{3'b001, 2'b10, 1'b0, 1'b0, 2'b10, 7'h20, 2'b01, 7'h11, 1'b0, 2'b10},
    '{3'b010, 2'b01, 1'b0, 1'b1, 2'b10, 7'h50, 2'b00, 7'h05, 1'b1, 2'b11},
    '{3'b000, 2'b01, 1'b0, 1'b1, 2'b11, 7'h10, 2'b00, 7'h05, 1'b1, 2'b11},
    '{3'b100, 2'b10, 1'b1, 1'b1, 2'b00, 7'h20, 2'b10, 7'h33, 1'b1, 2'b11},
    '{3'b010, 2'b10, 1'b1, 1'b1, 2'b00, 7'h50, 2'b01, 7'h11, 1'b0, 2'b11},
    '{3'b111, 2'b01, 1'b0, 1'b0, 2'b10, 7'h50, 2'b10, 7'h33, 1'b1, 2'b10},
    '{3'b000, 2'b01, 1'b1, 1'b1, 2'b11, 7'h10, 2'b00, 7'h05, 1'b1, 2'b11}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pwr_state = 2'b10; dual_gang = 1'b0; hwc_in = '0;
    buck_sw_en = 4'b1111; buck_hw_en = '0;
    buck_src      = {2'd0, 2'd2, 2'd0, 2'd1};
    buck_on_mode  = {2'b00, 2'b10, 2'b11, 2'b00};
    buck_on_vsel  = {7'h00, 7'h20, 7'h40, 7'h00};
    buck_slp_mode = {2'b00, 2'b11, 2'b00, 2'b00};
    buck_slp_vsel = {7'h00, 7'h10, 7'h00, 7'h00};
    buck_ovr_mode = {2'b00, 2'b10, 2'b01, 2'b01};
    buck_ovr_vsel = {7'h00, 7'h50, 7'h00, 7'h00};
    ldo_sw_en = 4'b1111; ldo_hw_en = '0;
    ldo_src = {2'd0, 2'd0, 2'd0, 2'd3};
    ldo_on_mode = 8'b00_00_00_01;  ldo_on_vsel = 28'h11;
    ldo_slp_mode = 8'b00_00_00_00; ldo_slp_vsel = 28'h05;
    ldo_ovr_mode = 8'b00_00_00_10; ldo_ovr_vsel = 28'h33;
    ldo_lp_type = 4'b0001; ldo_float = 4'b0000;
    swi_wr = 1'b0; swi_wdata = '0;
    epe_sw_en = 2'b11; epe_hw_en = '0; epe_src = {2'd1, 2'd1}; epe_ovr_off = 2'b01;

    tick(3);
    chk("reset buck_ena", 32'(buck_ena), 32'h0);
    chk("reset epe_out R7", 32'(epe_out), 32'h0);
    chk("reset switch flags R10", 32'(ldo_sw), 32'h0);
    rst_n = 1'b1;
    tick(4);

    // table: R2 R4 R5 R6 R7 R11
    for (int v = 0; v < 8; v++) begin
      hwc_in = VT[v].hwc; pwr_state = VT[v].st; dual_gang = VT[v].dual;
      tick(3);
      chk($sformatf("vector %0d R4 R5 R6 R7 R11", v),
          32'({buck_ena[0], buck_mode[5:4], buck_vsel[20:14], ldo_mode[1:0],
               ldo_vsel[6:0], ldo_lp[0], epe_out}),
          32'({VT[v].b0e, VT[v].b2m, VT[v].b2v, VT[v].l0m, VT[v].l0v,
               VT[v].l0lp, VT[v].epe}));
    end

    // R1 synchroniser latency
    pwr_state = 2'b10; dual_gang = 1'b0; hwc_in = 3'b000;
    tick(3);
    hwc_in = 3'b001;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 not yet after two edges", 32'(buck_ena[0]), 32'h1);
    tick(1);
    chk("R1 visible on third edge", 32'(buck_ena[0]), 32'h0);

    // R2 source 0 ignores asserted inputs even with a disabling override
    hwc_in = 3'b111;
    tick(3);
    chk("R2 unselected buck1 stays on", 32'(buck_ena[1]), 32'h1);
    hwc_in = 3'b000;
    tick(3);

    // R3 hardware enable gates the override
    buck_sw_en[0] = 1'b0;
    tick(1);
    chk("R3 buck0 off without enables", 32'(buck_ena[0]), 32'h0);
    buck_hw_en[0] = 1'b1;
    tick(1);
    chk("R3 buck0 on by hw enable", 32'(buck_ena[0]), 32'h1);
    hwc_in = 3'b001;
    tick(3);
    chk("R3 R5 override applies under hw enable", 32'(buck_ena[0]), 32'h0);
    hwc_in = 3'b000; buck_hw_en[0] = 1'b0; buck_sw_en[0] = 1'b1;
    tick(3);

    // R3 disabled channel ignores override for mode/voltage
    buck_sw_en[2] = 1'b0; hwc_in = 3'b010; buck_ovr_mode[5:4] = 2'b11;
    tick(3);
    chk("R3 disabled buck2 keeps awake settings",
        32'({buck_ena[2], buck_mode[5:4], buck_vsel[20:14]}), 32'({1'b0, 2'b10, 7'h20}));
    buck_sw_en[2] = 1'b1; hwc_in = 3'b000; buck_ovr_mode[5:4] = 2'b10;
    tick(3);

    // R12 one-edge config latency
    buck_on_vsel[20:14] = 7'h21;
    tick(1);
    chk("R12 config change after one edge", 32'(buck_vsel[20:14]), 32'h21);
    buck_on_vsel[20:14] = 7'h20;
    tick(1);

    // R10 write ignored outside awake state
    pwr_state = 2'b01; swi_wr = 1'b1; swi_wdata = 4'b0001;
    tick(1);
    swi_wr = 1'b0;
    tick(2);
    chk("R10 sleep-state write ignored", 32'({ldo_sw[0], ldo_vsel[6:0]}), 32'({1'b0, 7'h05}));

    // R10 R8 write in awake state
    pwr_state = 2'b10; swi_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    swi_wr = 1'b0;
    chk("R10 output not yet updated", 32'(ldo_sw[0]), 32'h0);
    tick(1);
    chk("R8 switch closed and controls zeroed",
        32'({ldo_sw[0], ldo_mode[1:0], ldo_vsel[6:0], ldo_lp[0]}),
        32'({1'b1, 2'b00, 7'h00, 1'b0}));

    // R8 R9 disabled in switch mode: open, no discharge
    ldo_sw_en[0] = 1'b0;
    tick(1);
    chk("R8 switch open, no discharge", 32'({ldo_sw[0], ldo_dis[0]}), 32'h0);

    // R9 leave switch mode while off
    swi_wr = 1'b1; swi_wdata = 4'b0000;
    @(posedge clk);
    @(negedge clk);
    swi_wr = 1'b0;
    tick(1);
    chk("R9 discharge when off", 32'({ldo_ena[0], ldo_dis[0]}), 32'({1'b0, 1'b1}));
    ldo_float[0] = 1'b1;
    tick(1);
    chk("R9 float when off", 32'(ldo_dis[0]), 32'h0);

    finish_run();
  end
endmodule